// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Bank

This block holds four 8-bit event counters. Each one sits next to a buffered capture channel. Every cycle in which a channel's event input is high adds one to that channel's live count. The channels are grouped into adjacent pairs. Each pair can be set to run as one 16-bit counter. In that mode the even channel is the low byte, and its carry advances the odd channel, which is the high byte.

A single shared latch strobe (typically produced by a periodic down-counter elsewhere) does three things in the same cycle:
- it copies every live count into that channel's holding register;
- it clears every live counter, so each held value covers exactly one period;
- it sets each channel's hold-valid flag.

Every channel also has a sticky overflow flag that records when its counter wraps.

The held counts are an outgoing data stream with a valid/ready handshake. `hold_valid[i]` is the valid signal and `hold_rd[i]` is the ready/accept pulse. The handshake applies no back-pressure on the producer side. A latch strobe always loads the holding register, even if the previous value was never read, and this sets valid again. A read in the same cycle as a latch is therefore lost, and valid stays high. The remaining pins are plain control and status: event inputs, latch strobe, pair configuration and overflow clears.

Top module: `pacc_bank`

## Requirements
- R1: After reset, every live count, held count, hold-valid flag and overflow flag is zero.
- R2: An unpaired channel increments its live count by one on every clock in which its event input is high. It wraps from 255 to 0.
- R3: When an unpaired channel wraps, it sets its overflow flag. The flag stays set, including across latch strobes, until an `ovf_clr` pulse on that channel clears it one cycle later.
- R4: When `pair_en[p]=1`, channel 2p is the low byte and channel 2p+1 is the high byte of one 16-bit counter. The high byte increments exactly when the low byte wraps from 255 to 0. Event input 2p+1 is ignored.
- R5: In pair mode, a 16-bit wrap from 0xFFFF to 0 sets the overflow flag of channel 2p+1. A carry out of the low byte never sets the overflow flag of channel 2p.
- R6: On a latch strobe, in the next cycle every held count equals the live count from the strobe cycle and every live count is zero. Events present in the strobe cycle are discarded.
- R7: Held counts change only as a result of a latch strobe.
- R8: A latch strobe sets all hold-valid flags in the next cycle. A `hold_rd[i]` pulse without a latch clears `hold_valid[i]` in the next cycle. A latch wins over a read in the same cycle, and it overwrites unread held values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 4 | Per-channel event input, counted once per high cycle |
| latch_stb | input | 1 | Shared snapshot-and-clear strobe |
| pair_en | input | 2 | Bit p joins channels 2p (low) and 2p+1 (high) |
| hold_rd | input | 4 | Per-channel accept pulse for the held count |
| ovf_clr | input | 4 | Per-channel overflow flag clear |
| live_cnt | output | 32 | Live counts, channel i at bits [8i+7:8i] |
| hold_cnt | output | 32 | Held counts, channel i at bits [8i+7:8i] |
| hold_valid | output | 4 | Held count unread since last latch |
| ovf_flag | output | 4 | Sticky overflow flags |

## Verification
The assertions check the following on every cycle:
- the snapshot-and-clear effect of a latch strobe;
- that held values stay put between strobes;
- the set and clear rules of hold-valid;
- that overflow flags are sticky;
- that an unpaired counter moves only when its event is high;
- that a paired high byte stays still unless the low byte carries.

Only the bench scenarios can show that the counts are arithmetically correct. These scenarios cover long mixed-rate event sweeps, the full 65536-event wrap of a joined pair, which overflow flag a wrap lands on, and the ordering of simultaneous latch and read.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic {
    PAIR_SPLIT  = 1'b0,
    PAIR_JOINED = 1'b1
  } pair_mode_e;

  // Increment request for the upper channel of a pair.
  function automatic logic high_step(pair_mode_e mode, logic own_evt, logic low_carry);
    return (mode == PAIR_JOINED) ? low_carry : own_evt;
  endfunction

endpackage

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ovf_en,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         carry,
  output logic         ovf
);

  localparam logic [W-1:0] CNT_MAX = '1;

  assign carry = inc && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ovf <= 1'b0;
    else if (carry && ovf_en && !clr)   ovf <= 1'b1;
    else if (ovf_clr)                   ovf <= 1'b0;
  end

endmodule

// File: rtl/pacc_hold.sv
module pacc_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         rd,
  output logic [W-1:0] q,
  output logic         valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (load) begin
      q     <= d;
      valid <= 1'b1;
    end else if (rd) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pacc_bank.sv
module pacc_bank
  import pacc_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   evt_in,
  input  logic           latch_stb,
  input  logic [N/2-1:0] pair_en,
  input  logic [N-1:0]   hold_rd,
  input  logic [N-1:0]   ovf_clr,
  output logic [N*W-1:0] live_cnt,
  output logic [N*W-1:0] hold_cnt,
  output logic [N-1:0]   hold_valid,
  output logic [N-1:0]   ovf_flag
);

  localparam int NP = N / 2;

  logic [W-1:0] cnt_q [N];
  logic [N-1:0] carry;
  logic [N-1:0] inc;
  logic [N-1:0] ovf_en;

  // Pair wiring: even channel is the low byte, odd channel the high byte.
  for (genvar p = 0; p < NP; p++) begin : g_pair
    pair_mode_e mode;
    assign mode = pair_en[p] ? PAIR_JOINED : PAIR_SPLIT;

    assign inc[2*p]      = evt_in[2*p];
    assign ovf_en[2*p]   = (mode == PAIR_SPLIT);
    assign inc[2*p+1]    = high_step(mode, evt_in[2*p+1], carry[2*p]);
    assign ovf_en[2*p+1] = 1'b1;
  end

  for (genvar c = 0; c < N; c++) begin : g_chan
    pacc_counter #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc[c]),
      .clr     (latch_stb),
      .ovf_en  (ovf_en[c]),
      .ovf_clr (ovf_clr[c]),
      .cnt     (cnt_q[c]),
      .carry   (carry[c]),
      .ovf     (ovf_flag[c])
    );

    pacc_hold #(.W(W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (latch_stb),
      .d     (cnt_q[c]),
      .rd    (hold_rd[c]),
      .q     (hold_cnt[c*W +: W]),
      .valid (hold_valid[c])
    );

    assign live_cnt[c*W +: W] = cnt_q[c];
  end

endmodule

// File: rtl/pacc_bank_chk.sv
module pacc_bank_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   evt_in,
  input logic           latch_stb,
  input logic [N/2-1:0] pair_en,
  input logic [N-1:0]   hold_rd,
  input logic [N-1:0]   ovf_clr,
  input logic [N*W-1:0] live_cnt,
  input logic [N*W-1:0] hold_cnt,
  input logic [N-1:0]   hold_valid,
  input logic [N-1:0]   ovf_flag
);

  localparam logic [W-1:0] LOW_MAX = '1;

  // R6
  latch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (live_cnt == '0));

  // R6
  latch_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (hold_cnt == $past(live_cnt)));

  // R7
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(hold_cnt));

  // R8
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (&hold_valid));

  for (genvar c = 0; c < N; c++) begin : g_ch
    // R8
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_rd[c] && !latch_stb) |=> !hold_valid[c]);

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[c] && !ovf_clr[c]) |=> ovf_flag[c]);

    if (c % 2 == 0) begin : g_even
      // R2
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_stb && !evt_in[c]) |=> $stable(live_cnt[c*W +: W]));
    end else begin : g_odd
      // R2
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_stb && !pair_en[c/2] && !evt_in[c]) |=> $stable(live_cnt[c*W +: W]));

      // R4
      high_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_stb && pair_en[c/2] &&
         !(evt_in[c-1] && (live_cnt[(c-1)*W +: W] == LOW_MAX)))
        |=> $stable(live_cnt[c*W +: W]));
    end
  end

endmodule

bind pacc_bank pacc_bank_chk #(.N(N), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_in     (evt_in),
  .latch_stb  (latch_stb),
  .pair_en    (pair_en),
  .hold_rd    (hold_rd),
  .ovf_clr    (ovf_clr),
  .live_cnt   (live_cnt),
  .hold_cnt   (hold_cnt),
  .hold_valid (hold_valid),
  .ovf_flag   (ovf_flag)
);

// File: tb/tb_pacc_bank.sv
module tb_pacc_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_in = '0;
  logic        latch_stb = 1'b0;
  logic [1:0]  pair_en = '0;
  logic [3:0]  hold_rd = '0;
  logic [3:0]  ovf_clr = '0;
  logic [31:0] live_cnt;
  logic [31:0] hold_cnt;
  logic [3:0]  hold_valid;
  logic [3:0]  ovf_flag;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pacc_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .latch_stb(latch_stb),
    .pair_en(pair_en), .hold_rd(hold_rd), .ovf_clr(ovf_clr),
    .live_cnt(live_cnt), .hold_cnt(hold_cnt), .hold_valid(hold_valid),
    .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_evt(input logic [3:0] mask, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) evt_in = mask;
    end
    @(negedge clk) evt_in = '0;
  endtask

  task automatic strobe(input logic lat, input logic [3:0] rd, input logic [3:0] clr,
                        input logic [3:0] ev);
    @(negedge clk) begin
      latch_stb = lat; hold_rd = rd; ovf_clr = clr; evt_in = ev;
    end
    @(negedge clk) begin
      latch_stb = 1'b0; hold_rd = '0; ovf_clr = '0; evt_in = '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_cnt;
    logic [3:0]  exp_ovf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 live", live_cnt, 32'h0);
    check("R1 hold", hold_cnt, 32'h0);
    check("R1 valid", hold_valid, 4'h0);
    check("R1 ovf", ovf_flag, 4'h0);

    // R2/R3: channel i sees an event on every (i+1)-th cycle over 300 cycles
    for (int s = 0; s < 300; s++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) evt_in[i] = ((s % (i + 1)) == 0);
    end
    @(negedge clk) evt_in = '0;
    exp_cnt = '0; exp_ovf = '0;
    for (int i = 0; i < 4; i++) begin
      int n;
      n = (300 + i) / (i + 1);
      exp_cnt[i*8 +: 8] = 8'(n % 256);
      exp_ovf[i] = (n >= 256);
    end
    check("R2 sweep counts", live_cnt, exp_cnt);
    check("R3 sweep overflow", ovf_flag, exp_ovf);

    // R6 snapshot and clear, R8 valid set, R3 flag survives latch
    strobe(1'b1, 4'h0, 4'h0, 4'h0);
    check("R6 held counts", hold_cnt, exp_cnt);
    check("R6 live cleared", live_cnt, 32'h0);
    check("R8 valid set", hold_valid, 4'hF);
    check("R3 ovf kept over latch", ovf_flag, exp_ovf);

    // R8 read of channel 1 only; R7 hold unchanged
    strobe(1'b0, 4'h2, 4'h0, 4'h0);
    check("R8 read clears one", hold_valid, 4'hD);
    check("R7 hold unchanged by read", hold_cnt, exp_cnt);

    // R3 clear
    strobe(1'b0, 4'h0, 4'h1, 4'h0);
    check("R3 ovf cleared", ovf_flag, 4'h0);

    // R6 events during strobe cycle discarded; R8 latch overwrites unread
    strobe(1'b1, 4'h0, 4'h0, 4'hF);
    check("R6 strobe events dropped", live_cnt, 32'h0);
    check("R6 overwrite with zero", hold_cnt, 32'h0);
    check("R8 valid all set again", hold_valid, 4'hF);

    // R7 events alone do not change holds
    pulse_evt(4'hF, 7);
    check("R7 hold steady under events", hold_cnt, 32'h0);
    strobe(1'b1, 4'h0, 4'h0, 4'h0);
    check("R6 small snapshot", hold_cnt, 32'h07070707);

    // R4 pair 0 joined, event on channel 1 ignored
    pair_en = 2'b01;
    pulse_evt(4'h3, 300);
    check("R4 joined 300", live_cnt, 32'h0000012C);
    check("R5 no ovf mid", ovf_flag, 4'h0);

    // R5 full 16-bit wrap
    pulse_evt(4'h1, 65536 - 300);
    check("R5 joined wrap count", live_cnt, 32'h0);
    check("R5 ovf on high channel", ovf_flag, 4'h2);
    strobe(1'b0, 4'h0, 4'hF, 4'h0);

    // R4/R2 joined pair 0 plus split pair 1, then latch with read same cycle
    pulse_evt(4'h5, 513);
    check("R4 joined 513", live_cnt[15:0], 16'h0201);
    check("R2 split ch2 wrap", live_cnt[31:16], 16'h0001);
    check("R3 split ch2 ovf", ovf_flag, 4'h4);
    strobe(1'b1, 4'hF, 4'h0, 4'h0);
    check("R8 latch wins over read", hold_valid, 4'hF);
    check("R6 joined snapshot", hold_cnt, 32'h00010201);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule